// File: doc/BRIEF.md
# Iterative Rotate and Arithmetic Shifter

This block moves the bits of a 24-bit accumulator, or of the 48-bit pair formed by the accumulator and an auxiliary register, by up to 63 places. It can rotate or shift arithmetically, in either direction. A decoder outside the block supplies a direction bit, a mode bit, a precision bit and a 6-bit place count. The block also receives the current register values.

A start strobe captures the operands and the control bits. The block then moves the value one place on each clock, using a down-counter. When the counter is exhausted, the block raises a one-cycle done strobe, and the results wait on the outputs. A start strobe that arrives while an operation is running is ignored.

Top module: `acc_shift_unit`

## Requirements
- R1: The direction input `op_right` selects the direction: 0 moves bits toward the high end (left) and 1 moves them toward the low end (right).
- R2: With `op_arith` = 0 the operation is a rotate: every bit that leaves one end of the operand re-enters at the other end.
- R3: With `op_arith` = 1 and a left move, the bits shifted out are lost and the vacated low positions are filled with zeros.
- R4: With `op_arith` = 1 and a right move, the bits shifted out are lost and the vacated high positions are filled with copies of bit 23 of A. In double precision this sign fill extends across all 48 bits.
- R5: With `op_dbl` = 0 only A is moved, and `b_out` returns `b_in` unchanged.
- R6: With `op_dbl` = 1, A and B form one 48-bit value with A as the high half, so bits cross between B bit 23 and A bit 0.
- R7: A count of n produces `done` exactly n+1 clocks after the edge that samples `start`. The value moves one place per clock, and `busy` is high from the sampling edge until `done` rises.
- R8: A count of 0 returns both registers unchanged, and `done` still rises one clock after `start`.
- R9: `done` is high for exactly one clock per accepted start.
- R10: A `start` pulse while `busy` is high changes neither the result nor the timing of the operation in progress.
- R11: After reset `a_out`, `b_out`, `busy` and `done` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| op_right | input | 1 | 0 = left, 1 = right |
| op_arith | input | 1 | 0 = rotate, 1 = arithmetic |
| op_dbl | input | 1 | 0 = A alone, 1 = A:B as 48 bits |
| count | input | 6 | Number of places to move |
| a_in | input | 24 | Accumulator operand |
| b_in | input | 24 | Auxiliary operand |
| a_out | output | 24 | Accumulator result |
| b_out | output | 24 | Auxiliary result |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The most likely internal faults are a wrong fill bit or a lost carry between the halves. Either one corrupts `a_out` or `b_out` as soon as `done` rises, and a count of 1 already exposes it. An off-by-one in the down-counter does not stay hidden: it moves `done` a clock early or late and also leaves the result one place wrong, so the cycle count and the data disagree together. A start that is wrongly accepted while busy reloads the operands, which shows up as a different result or as a late `done`.

// File: rtl/shift_pkg.sv
package shift_pkg;
  localparam int unsigned WORD_W = 24;
  localparam int unsigned CNT_W  = 6;
  localparam int unsigned PAIR_W = 2 * WORD_W;

  typedef struct packed {
    logic right;
    logic arith;
    logic dbl;
  } shift_ctl_t;
endpackage

// File: rtl/shift_step.sv
module shift_step
  import shift_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  shift_ctl_t   ctl,
  input  logic [W-1:0] a_cur,
  input  logic [W-1:0] b_cur,
  output logic [W-1:0] a_nxt,
  output logic [W-1:0] b_nxt
);
  localparam int unsigned PW = 2 * W;

  logic [PW-1:0] pair;
  logic [PW-1:0] pair_mv;
  logic [W-1:0]  single_mv;
  logic          sign;

  assign pair = {a_cur, b_cur};
  assign sign = a_cur[W-1];

  always_comb begin
    if (ctl.right) begin
      pair_mv   = {(ctl.arith ? sign : pair[0]), pair[PW-1:1]};
      single_mv = {(ctl.arith ? sign : a_cur[0]), a_cur[W-1:1]};
    end else begin
      pair_mv   = {pair[PW-2:0], (ctl.arith ? 1'b0 : pair[PW-1])};
      single_mv = {a_cur[W-2:0], (ctl.arith ? 1'b0 : a_cur[W-1])};
    end
  end

  always_comb begin
    if (ctl.dbl) begin
      a_nxt = pair_mv[PW-1:W];
      b_nxt = pair_mv[W-1:0];
    end else begin
      a_nxt = single_mv;
      b_nxt = b_cur;
    end
  end
endmodule

// File: rtl/shift_count.sv
module shift_count #(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          zero
);
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = load | dec;
  assign zero   = (cnt == '0);

  always_comb begin
    if (load) cnt_d = load_val;
    else      cnt_d = cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |=> (cnt == $past(cnt) - 1'b1)); // R7
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
  import shift_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_right,
  input  logic          op_arith,
  input  logic          op_dbl,
  input  logic [CW-1:0] count,
  input  logic [W-1:0]  a_in,
  input  logic [W-1:0]  b_in,
  output logic [W-1:0]  a_out,
  output logic [W-1:0]  b_out,
  output logic          busy,
  output logic          done
);
  shift_ctl_t    ctl_q, ctl_d;
  logic [W-1:0]  a_q, a_d, b_q, b_d;
  logic [W-1:0]  a_step, b_step;
  logic          busy_q, busy_d, done_q, done_d;
  logic          accept, stepping, cnt_zero;
  logic [CW-1:0] cnt;
  logic          data_en, ctl_en;

  assign accept   = start & ~busy_q;
  assign stepping = busy_q & ~cnt_zero;
  assign data_en  = accept | stepping;
  assign ctl_en   = accept;

  shift_count #(.CW(CW)) i_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_val (count),
    .dec      (stepping),
    .cnt      (cnt),
    .zero     (cnt_zero)
  );

  shift_step #(.W(W)) i_step (
    .ctl   (ctl_q),
    .a_cur (a_q),
    .b_cur (b_q),
    .a_nxt (a_step),
    .b_nxt (b_step)
  );

  always_comb begin
    ctl_d  = '{right: op_right, arith: op_arith, dbl: op_dbl};
    a_d    = accept ? a_in : a_step;
    b_d    = accept ? b_in : b_step;
    busy_d = accept | (busy_q & ~cnt_zero);
    done_d = busy_q & cnt_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else if (data_en) begin
      a_q <= a_d;
      b_q <= b_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_en) ctl_q <= ctl_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign a_out = a_q;
  assign b_out = b_q;
  assign busy  = busy_q;
  assign done  = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_B_KEPT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ctl_q.dbl && !cnt_zero) |=> $stable(b_out)); // R5
  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctl_q.arith && ctl_q.right && !cnt_zero) |=> $stable(a_out[W-1])); // R4
  AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && count == '0) |=> busy ##1 (done && !busy)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(ctl_q)); // R10
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy)); // R7
endmodule

// File: tb/test_acc_shift_unit.sv
module test_acc_shift_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, op_right, op_arith, op_dbl;
  logic [5:0]  count;
  logic [23:0] a_in, b_in, a_out, b_out;
  logic        busy, done;
  int          n_chk = 0;
  int          n_bad = 0;

  always #10 clk = ~clk;

  acc_shift_unit i_acc_shift_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .op_right(op_right),
    .op_arith(op_arith), .op_dbl(op_dbl), .count(count), .a_in(a_in),
    .b_in(b_in), .a_out(a_out), .b_out(b_out), .busy(busy), .done(done)
  );

  // {right, arith, dbl, count, a, b}
  localparam int NV = 12;
  localparam logic [56:0] VEC [NV] = '{
    {1'b0, 1'b0, 1'b0, 6'd4,  24'h800001, 24'h123456},  // R1 R2 R5 rotate left
    {1'b1, 1'b0, 1'b0, 6'd1,  24'h000001, 24'hABCDEF},  // R2 rotate right wrap
    {1'b0, 1'b1, 1'b0, 6'd3,  24'hF00001, 24'h555555},  // R3 left zero fill
    {1'b1, 1'b1, 1'b0, 6'd5,  24'h800010, 24'h0F0F0F},  // R4 sign fill
    {1'b1, 1'b1, 1'b0, 6'd7,  24'h400080, 24'h000000},  // R4 positive
    {1'b0, 1'b0, 1'b1, 6'd1,  24'h800000, 24'h800000},  // R6 pair rotate left
    {1'b1, 1'b0, 1'b1, 6'd2,  24'h000003, 24'h000001},  // R6 pair rotate right
    {1'b0, 1'b1, 1'b1, 6'd30, 24'h000000, 24'h0000FF},  // R3 R6 pair left
    {1'b1, 1'b1, 1'b1, 6'd28, 24'h812345, 24'h6789AB},  // R4 R6 pair sign fill
    {1'b1, 1'b0, 1'b1, 6'd48, 24'hC0FFEE, 24'h123456},  // R2 full rotate
    {1'b0, 1'b0, 1'b1, 6'd63, 24'h000001, 24'h800000},  // R7 max count
    {1'b1, 1'b1, 1'b1, 6'd0,  24'h9ABCDE, 24'h112233}   // R8 zero count
  };

  function automatic logic [47:0] model(input logic r, input logic ar,
      input logic d, input int n, input logic [23:0] a, input logic [23:0] b);
    logic [47:0] v;
    logic [23:0] s;
    v = {a, b};
    s = a;
    for (int i = 0; i < n; i++) begin
      if (d) begin
        if (r) v = ar ? {v[47], v[47:1]} : {v[0], v[47:1]};
        else   v = ar ? {v[46:0], 1'b0}  : {v[46:0], v[47]};
      end else begin
        if (r) s = ar ? {s[23], s[23:1]} : {s[0], s[23:1]};
        else   s = ar ? {s[22:0], 1'b0}  : {s[22:0], s[23]};
      end
    end
    return d ? v : {s, b};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic r, input logic ar, input logic d, input logic [5:0] n,
      input logic [23:0] a, input logic [23:0] b, input bit poke, output int cyc);
    @(negedge clk);
    op_right = r; op_arith = ar; op_dbl = d; count = n; a_in = a; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    for (int k = 0; k < 200; k++) begin
      if (poke && k == 1) begin
        start = 1'b1; op_right = ~r; op_dbl = ~d; count = 6'd0;
        a_in = ~a; b_in = ~b;
      end else start = 1'b0;
      @(negedge clk);
      cyc++;
      if (done) break;
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int cyc;
    logic [47:0] e;
    rst_n = 1'b0; start = 1'b0; op_right = 1'b0; op_arith = 1'b0; op_dbl = 1'b0;
    count = '0; a_in = '0; b_in = '0;
    repeat (3) @(negedge clk);
    check("R11 reset", {a_out, b_out, busy, done}, '0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      run(VEC[i][56], VEC[i][55], VEC[i][54], VEC[i][53:48], VEC[i][47:24], VEC[i][23:0], 1'b0, cyc);
      e = model(VEC[i][56], VEC[i][55], VEC[i][54], int'(VEC[i][53:48]), VEC[i][47:24], VEC[i][23:0]);
      check("R1-6 result", {a_out, b_out}, e);
      check("R7 latency", cyc, int'(VEC[i][53:48]) + 1);
      @(negedge clk);
      check("R9 done one cycle", {done, busy}, 2'b00);
    end

    // R5 single precision keeps B even across many places
    run(1'b0, 1'b0, 1'b0, 6'd37, 24'h00F00F, 24'hDEAD01, 1'b0, cyc);
    check("R5 b untouched", b_out, 24'hDEAD01);
    check("R2 single rotate 37", a_out, model(1'b0, 1'b0, 1'b0, 37, 24'h00F00F, 24'h0)[47:24]);

    // R8 zero count in single mode
    run(1'b0, 1'b1, 1'b0, 6'd0, 24'h7FFFFF, 24'h000001, 1'b0, cyc);
    check("R8 zero count data", {a_out, b_out}, {24'h7FFFFF, 24'h000001});
    check("R8 zero count latency", cyc, 1);

    // R10 start while busy
    run(1'b0, 1'b0, 1'b1, 6'd10, 24'h123456, 24'h789ABC, 1'b1, cyc);
    check("R10 ignored start data", {a_out, b_out}, model(1'b0, 1'b0, 1'b1, 10, 24'h123456, 24'h789ABC));
    check("R10 ignored start latency", cyc, 11);

    // R11 reset mid-operation
    run(1'b1, 1'b1, 1'b1, 6'd1, 24'hFFFFFF, 24'hFFFFFF, 1'b0, cyc);
    @(negedge clk);
    op_dbl = 1'b1; count = 6'd20; a_in = 24'h1; b_in = 24'h1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    rst_n = 1'b0;
    @(negedge clk);
    check("R11 reset mid op", {a_out, b_out, busy, done}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule